// File: doc/BRIEF.md
# Relocatable Two-Window Address Decoder

This block sits between a bus master, such as a processor core or a DMA engine, and the on-chip targets. It sorts every 24-bit data address into exactly one of three destinations. The first is a 4 KB register window. The second is a 512-byte message buffer RAM window. Anything that misses both goes to the default external path. The block raises one select line for the chosen destination and passes on the local offset inside the chosen window. A separate select marks the lowest 512 bytes of the register window, where the message object registers live.

Software places both windows through four byte-wide configuration registers, which are written over a simple write port. Each window has its own enable bit. After reset both windows have known bases but are switched off, so every address goes to the external path until software turns a window on. Address decoding is combinational and uses the current register contents. A register write is seen by the decoder from the next clock edge onward.

Top module: `mem_window_router`

## Requirements
- R1: After reset the register window base is 0FF000h and both enables are 0. With the enables still 0, every address (0FF000h included) asserts only `sel_ext`.
- R2: Configuration writes use `cfg_sel`. Code 0 is the register window high base byte, which holds address bits 23..16. Code 1 is the low base byte: bits 7..4 hold address bits 15..12, bit 0 is the register window enable, and bits 3..1 are ignored. Code 2 is the segment byte. Code 3 is the RAM base byte: bits 7..1 hold address bits 15..9 and bit 0 is the RAM window enable.
- R3: When the register window is enabled, `sel_reg` is 1 exactly when address bits 23..12 equal {high byte, low byte bits 7..4}.
- R4: `sel_obj` is 1 exactly when `sel_reg` is 1 and the local offset is below 200h.
- R5: When the RAM window is enabled, an address hits the RAM window when its bits 23..9 equal {segment byte, RAM base bits 7..1}.
- R6: If an address matches both enabled windows, only `sel_reg` is asserted.
- R7: Exactly one of `sel_reg`, `sel_ram` and `sel_ext` is 1 in every cycle. `sel_ext` is 1 when neither window claims the address.
- R8: `reg_offset` equals address bits 11..0 while `sel_reg` is 1, and is 0 otherwise. `ram_offset` equals address bits 8..0 while `sel_ram` is 1, and is 0 otherwise.
- R9: A configuration write changes the decode only after the clock edge that captures it. Before that edge the decode follows the old contents.
- R10: Clearing a window's enable bit stops that window from decoding. Addresses that only the other window matches then go to the window that is still enabled, and all other addresses go to `sel_ext`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 24 | Data address from the bus master |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register code |
| cfg_wdata | input | 8 | Configuration write data |
| sel_reg | output | 1 | Address falls in the register window |
| sel_obj | output | 1 | Address falls in the object register sub-block |
| sel_ram | output | 1 | Address falls in the message buffer RAM window |
| sel_ext | output | 1 | Address goes to the default external path |
| reg_offset | output | 12 | Local offset in the register window |
| ram_offset | output | 9 | Local offset in the RAM window |

## Verification
Two things can happen in the same cycle. First, both windows can match one address. The bench provokes this by placing the RAM window inside the register window. It then checks that only the register select is raised and that the RAM offset stays 0. After that it clears the register enable and checks that the same address moves to the RAM window. Second, a configuration write can coincide with a live address. The bench drives the write and a target address together and samples the decode twice, once before the capturing edge and once after it, to confirm that the old contents apply until that edge.

// File: rtl/mem_window_router.sv
module mem_window_router #(
  parameter int         ADDR_W    = 24,
  parameter int         REG_AW    = 12,
  parameter int         RAM_AW    = 9,
  parameter int         OBJ_AW    = 9,
  parameter logic [7:0] HI_RST    = 8'h0F,
  parameter logic [7:0] LO_RST    = 8'hF0,
  parameter logic [7:0] SEG_RST   = 8'h00,
  parameter logic [7:0] RBASE_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic              sel_reg,
  output logic              sel_obj,
  output logic              sel_ram,
  output logic              sel_ext,
  output logic [REG_AW-1:0] reg_offset,
  output logic [RAM_AW-1:0] ram_offset
);
  localparam int REG_TAG_W = ADDR_W - REG_AW;
  localparam int RAM_TAG_W = ADDR_W - RAM_AW;
  localparam int LO_BITS   = REG_TAG_W - 8;
  localparam int RB_BITS   = RAM_TAG_W - 8;

  logic [7:0]         win_hi;
  logic [LO_BITS-1:0] win_lo;
  logic               win_en;
  logic [7:0]         seg;
  logic [RB_BITS-1:0] rbase;
  logic               ram_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_hi <= HI_RST;
      win_lo <= LO_RST[7 -: LO_BITS];
      win_en <= 1'b0;
      seg    <= SEG_RST;
      rbase  <= RBASE_RST[7 -: RB_BITS];
      ram_en <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: win_hi <= cfg_wdata;
        2'd1: begin
          win_lo <= cfg_wdata[7 -: LO_BITS];
          win_en <= cfg_wdata[0];
        end
        2'd2: seg <= cfg_wdata;
        default: begin
          rbase  <= cfg_wdata[7 -: RB_BITS];
          ram_en <= cfg_wdata[0];
        end
      endcase
    end
  end

  wire reg_hit = win_en && (bus_addr[ADDR_W-1 -: REG_TAG_W] == {win_hi, win_lo});
  wire ram_hit = ram_en && (bus_addr[ADDR_W-1 -: RAM_TAG_W] == {seg, rbase});

  assign sel_reg    = reg_hit;
  assign sel_ram    = ram_hit && !reg_hit;
  assign sel_ext    = !reg_hit && !ram_hit;
  assign sel_obj    = reg_hit && (bus_addr[REG_AW-1:OBJ_AW] == '0);
  assign reg_offset = reg_hit ? bus_addr[REG_AW-1:0] : '0;
  assign ram_offset = sel_ram ? bus_addr[RAM_AW-1:0] : '0;

  a_r7_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({sel_reg, sel_ram, sel_ext}));

  a_r4_obj_in_reg: assert property (@(posedge clk) disable iff (!rst_n)
    sel_obj |-> (sel_reg && reg_offset < REG_AW'(1 << OBJ_AW)));

  a_r8_ext_no_offset: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ext |-> (reg_offset == '0 && ram_offset == '0));

  a_r9_enable_next_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd1) |=> (win_en == $past(cfg_wdata[0])));

  a_r6_ram_yields: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ram |-> (sel_reg == 1'b0 && reg_offset == '0));
endmodule

// File: tb/test_mem_window_router.sv
module test_mem_window_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        sel_reg, sel_obj, sel_ram, sel_ext;
  logic [11:0] reg_offset;
  logic [8:0]  ram_offset;
  int          n_vec = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  mem_window_router i_mem_window_router (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .sel_reg(sel_reg),
    .sel_obj(sel_obj), .sel_ram(sel_ram), .sel_ext(sel_ext),
    .reg_offset(reg_offset), .ram_offset(ram_offset));

  // {addr, {reg,obj,ram,ext}, reg_offset, ram_offset}
  localparam logic [48:0] VEC [12] = '{
    {24'h123000, 4'b1100, 12'h000, 9'h000},
    {24'h1231FF, 4'b1100, 12'h1FF, 9'h000},
    {24'h123200, 4'b1000, 12'h200, 9'h000},
    {24'h123FFF, 4'b1000, 12'hFFF, 9'h000},
    {24'h122FFF, 4'b0001, 12'h000, 9'h000},
    {24'h124000, 4'b0010, 12'h000, 9'h000},
    {24'h1240A5, 4'b0010, 12'h000, 9'h0A5},
    {24'h1241FF, 4'b0010, 12'h000, 9'h1FF},
    {24'h124200, 4'b0001, 12'h000, 9'h000},
    {24'h123E00, 4'b1000, 12'hE00, 9'h000},
    {24'h0FF000, 4'b0001, 12'h000, 9'h000},
    {24'h134000, 4'b0001, 12'h000, 9'h000}
  };

  task automatic chk(input string req, input logic [3:0] es,
                     input logic [11:0] ero, input logic [8:0] emo);
    n_vec++;
    if ({sel_reg, sel_obj, sel_ram, sel_ext} !== es || reg_offset !== ero || ram_offset !== emo) begin
      n_bad++;
      $display("FAIL %s addr=%h sel=%b/%b roff=%h/%h moff=%h/%h", req, bus_addr,
               {sel_reg, sel_obj, sel_ram, sel_ext}, es, reg_offset, ero, ram_offset, emo);
    end
  endtask

  task automatic probe(input logic [23:0] a, input string req, input logic [3:0] es,
                       input logic [11:0] ero, input logic [8:0] emo);
    @(negedge clk);
    bus_addr = a;
    #1 chk(req, es, ero, emo);
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset base 0FF000h but both windows off
    probe(24'h0FF000, "R1", 4'b0001, 12'h0, 9'h0);
    probe(24'h000000, "R1", 4'b0001, 12'h0, 9'h0);
    // R9: enable write coinciding with a live address; old decode before edge
    @(negedge clk);
    bus_addr = 24'h0FF123;
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = 8'hF1;
    #1 chk("R9 before edge", 4'b0001, 12'h0, 9'h0);
    @(negedge clk);
    cfg_we = 1'b0;
    #1 chk("R9 after edge R3", 4'b1100, 12'h123, 9'h0);
    // R2: bits 3..1 of the low byte are ignored
    wr(2'd1, 8'hFF);
    probe(24'h0FF800, "R2 ignored bits", 4'b1000, 12'h800, 9'h0);
    // table configuration: regwin 123000h, RAM 124000h
    wr(2'd0, 8'h12);
    wr(2'd1, 8'h31);
    wr(2'd2, 8'h12);
    wr(2'd3, 8'h41);
    foreach (VEC[i]) begin
      probe(VEC[i][48:25], "R3/R4/R5/R7/R8 table", VEC[i][24:21], VEC[i][20:9], VEC[i][8:0]);
    end
    // R6: RAM window placed inside register window at 123400h
    wr(2'd3, 8'h35);
    probe(24'h123410, "R6 overlap", 4'b1000, 12'h410, 9'h0);
    // R10: disable register window, RAM takes the overlap
    wr(2'd1, 8'h30);
    probe(24'h123410, "R10 reg off", 4'b0010, 12'h0, 9'h010);
    probe(24'h123000, "R10 reg off", 4'b0001, 12'h0, 9'h0);
    // R10: disable RAM window as well
    wr(2'd3, 8'h34);
    probe(24'h123410, "R10 both off", 4'b0001, 12'h0, 9'h0);
    // R5: segment change moves RAM window
    wr(2'd2, 8'hA0);
    wr(2'd3, 8'h35);
    probe(24'hA035FF, "R5 segment", 4'b0010, 12'h0, 9'h1FF);
    probe(24'h1235FF, "R5 old segment", 4'b0001, 12'h0, 9'h0);
    // R1: reset again restores disabled state
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    probe(24'hA03500, "R1 re-reset", 4'b0001, 12'h0, 9'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule